// File: doc/BRIEF.md
# Address-Steered Flash Chip-Select Router

This block sits beside a serial flash bus and listens without driving anything except chip-select. The host talks to a primary flash device. The block samples the bus clock, data-in and the host chip-select in its own clock domain, and decodes the opcode and 24-bit address of each transaction. Clock and data wires are shared by both flash devices, so the only thing needed to redirect accesses is to choose which device receives the host's chip-select.

Two address windows set the routing. Each window is an inclusive pair of start and end addresses. A read whose address falls in the arm window moves later transactions to the secondary device. A read whose address falls in the release window moves them back to the primary device. The change waits until the host releases chip-select, so no transaction is ever split between the two devices. An enable input returns everything to the primary device at once.

Top module: `spi_cs_router`

## Requirements
- R1: After reset the block routes to the primary device: with host chip-select low, `cs_pri_n` is low and `cs_sec_n` is high.
- R2: When host chip-select is high, both outputs are high. When it is low, exactly one output is low.
- R3: A transaction is decoded as an 8-bit opcode followed by a 24-bit address. Both are sent MSB first and sampled on rising SCK (mode 0). A read (opcode 0x03) whose address satisfies arm_lo <= addr <= arm_hi routes later transactions to the secondary device.
- R4: A read whose address satisfies rel_lo <= addr <= rel_hi routes later transactions back to the primary device.
- R5: When a read address lies inside both windows, the release window wins and routing goes to the primary device.
- R6: A routing change takes effect only after host chip-select has been deasserted. The transaction that caused the change finishes on the device it started on.
- R7: Opcodes other than 0x03 never change routing, even when their address lies in a window. Their chip-select still reaches the currently selected device.
- R8: While `enable` is low, routing is forced to the primary device and any armed state is cleared. When `enable` returns high, routing stays on the primary device until a new arm-window read arrives.
- R9: A read whose address lies outside both windows, or a transaction that ends before all 32 opcode and address bits have arrived, leaves routing unchanged.
- R10: Window bounds are inclusive. An address equal to the start or the end of a window matches it. The address one below the start and the address one above the end do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, much faster than SCK |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Low forces primary routing and clears armed state |
| arm_lo | input | 24 | Arm window start address (inclusive) |
| arm_hi | input | 24 | Arm window end address (inclusive) |
| rel_lo | input | 24 | Release window start address (inclusive) |
| rel_hi | input | 24 | Release window end address (inclusive) |
| host_sck | input | 1 | Snooped bus clock |
| host_cs_n | input | 1 | Host chip-select, active low |
| host_mosi | input | 1 | Snooped host data-out line |
| cs_pri_n | output | 1 | Chip-select to the primary device |
| cs_sec_n | output | 1 | Chip-select to the secondary device |

## Verification
The bench sweeps addresses one below, at and one above every window bound. A design that got the comparisons wrong by one address would arm or release on a neighbour address, or miss an edge address. The bench samples chip-select near the end of each triggering frame: a design that switched devices mid-frame would show the secondary select active inside the frame that armed it. It also covers an address inside both windows, where a design with the wrong priority would arm. Other cases are a write opcode aimed at an arm address and a frame cut short after 20 bits, which a design that ignored the opcode or decided too early would act on. Finally, toggling `enable` while armed would leave a design that only masked its output still on the secondary device afterwards.

// File: rtl/spi_cs_router.sv
module spi_cs_router #(
  parameter int          ADDR_W  = 24,
  parameter int          OP_W    = 8,
  parameter logic [7:0]  READ_OP = 8'h03,
  parameter int          SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [ADDR_W-1:0] arm_lo,
  input  logic [ADDR_W-1:0] arm_hi,
  input  logic [ADDR_W-1:0] rel_lo,
  input  logic [ADDR_W-1:0] rel_hi,
  input  logic              host_sck,
  input  logic              host_cs_n,
  input  logic              host_mosi,
  output logic              cs_pri_n,
  output logic              cs_sec_n
);
  localparam int FRAME_W = OP_W + ADDR_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [SYNC_N-1:0]  sck_sync, cs_sync, mosi_sync;
  logic               sck_d;
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   bit_cnt;
  logic               pend_v, pend_sec, route_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sync  <= '0;
      cs_sync   <= '1;
      mosi_sync <= '0;
      sck_d     <= 1'b0;
    end else begin
      sck_sync  <= {sck_sync[SYNC_N-2:0], host_sck};
      cs_sync   <= {cs_sync[SYNC_N-2:0], host_cs_n};
      mosi_sync <= {mosi_sync[SYNC_N-2:0], host_mosi};
      sck_d     <= sck_sync[SYNC_N-1];
    end
  end

  wire cs_idle  = cs_sync[SYNC_N-1];
  wire sck_rise = sck_sync[SYNC_N-1] & ~sck_d;
  wire [FRAME_W-1:0] shnext = {shreg[FRAME_W-2:0], mosi_sync[SYNC_N-1]};
  wire [OP_W-1:0]    op     = shnext[FRAME_W-1 -: OP_W];
  wire [ADDR_W-1:0]  addr   = shnext[ADDR_W-1:0];
  wire frame_done = ~cs_idle & sck_rise & (bit_cnt == CNT_W'(FRAME_W - 1));
  wire is_read    = (op == OP_W'(READ_OP));
  wire hit_arm    = (addr >= arm_lo) && (addr <= arm_hi);
  wire hit_rel    = (addr >= rel_lo) && (addr <= rel_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (cs_idle) begin
      bit_cnt <= '0;
    end else if (sck_rise && bit_cnt != CNT_W'(FRAME_W)) begin
      shreg   <= shnext;
      bit_cnt <= bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v   <= 1'b0;
      pend_sec <= 1'b0;
      route_q  <= 1'b0;
    end else if (!enable) begin
      pend_v   <= 1'b0;
      pend_sec <= 1'b0;
      route_q  <= 1'b0;
    end else if (frame_done && is_read && (hit_arm || hit_rel)) begin
      pend_v   <= 1'b1;
      pend_sec <= ~hit_rel;
    end else if (pend_v && cs_idle && host_cs_n) begin
      route_q  <= pend_sec;
      pend_v   <= 1'b0;
    end
  end

  wire sel_sec = route_q & enable;
  assign cs_pri_n = host_cs_n | sel_sec;
  assign cs_sec_n = host_cs_n | ~sel_sec;
endmodule

// File: rtl/spi_cs_router_chk.sv
module spi_cs_router_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic host_cs_n,
  input logic cs_pri_n,
  input logic cs_sec_n,
  input logic route_q
);
  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    host_cs_n |-> (cs_pri_n && cs_sec_n)); // R2
  AST_ONE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !host_cs_n |-> ($countones({~cs_pri_n, ~cs_sec_n}) == 1)); // R2
  AST_NO_MIDFRAME_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!host_cs_n) && $past(enable)) |-> $stable(route_q)); // R6
  AST_ENABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!enable) |-> !route_q); // R8
  AST_DISABLED_PRIMARY: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !host_cs_n) |-> (!cs_pri_n && cs_sec_n)); // R8
endmodule

bind spi_cs_router spi_cs_router_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .host_cs_n(host_cs_n),
  .cs_pri_n(cs_pri_n), .cs_sec_n(cs_sec_n), .route_q(route_q)
);

// File: tb/spi_cs_router_tb.sv
module spi_cs_router_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b1;
  logic [23:0] arm_lo = 24'h001000, arm_hi = 24'h001FFF;
  logic [23:0] rel_lo = 24'h00F000, rel_hi = 24'h00F0FF;
  logic host_sck = 1'b0, host_cs_n = 1'b1, host_mosi = 1'b0;
  logic cs_pri_n, cs_sec_n;
  logic mid_pri_n;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  spi_cs_router u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .arm_lo(arm_lo), .arm_hi(arm_hi), .rel_lo(rel_lo), .rel_hi(rel_hi),
    .host_sck(host_sck), .host_cs_n(host_cs_n), .host_mosi(host_mosi),
    .cs_pri_n(cs_pri_n), .cs_sec_n(cs_sec_n)
  );

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] op, input logic [23:0] a, input int nbits);
    logic [39:0] fr;
    fr = {op, a, 8'hA5};
    host_cs_n = 1'b0;
    wclk(8);
    for (int i = 0; i < nbits; i++) begin
      host_mosi = fr[39 - i];
      wclk(8);
      host_sck = 1'b1;
      wclk(8);
      host_sck = 1'b0;
    end
    wclk(8);
    mid_pri_n = cs_pri_n;
    host_cs_n = 1'b1;
    wclk(10);
  endtask

  task automatic probe(input logic exp_sec, input string tag);
    check(cs_pri_n, 1'b1, {tag, " idle pri"});
    check(cs_sec_n, 1'b1, {tag, " idle sec"});
    host_cs_n = 1'b0;
    wclk(2);
    check(cs_pri_n, exp_sec, {tag, " pri"});
    check(cs_sec_n, ~exp_sec, {tag, " sec"});
    host_cs_n = 1'b1;
    wclk(6);
  endtask

  task automatic disarm();
    enable = 1'b0;
    wclk(3);
    enable = 1'b1;
    wclk(3);
  endtask

  initial begin
    wclk(4);
    rst_n = 1'b1;
    wclk(4);
    probe(1'b0, "R1 reset");

    foreach (arm_lo[i]) begin end
    for (int b = 0; b < 2; b++) begin
      for (int d = -1; d <= 1; d++) begin
        logic [23:0] a;
        logic hit;
        a = (b == 0) ? arm_lo + 24'(d) : arm_hi + 24'(d);
        hit = (a >= arm_lo) && (a <= arm_hi);
        disarm();
        send(8'h03, a, 40);
        if (hit) check(mid_pri_n, 1'b0, "R6 frame stays primary");
        probe(hit, "R3 R10 arm bound");
      end
    end

    for (int b = 0; b < 2; b++) begin
      for (int d = -1; d <= 1; d++) begin
        logic [23:0] a;
        logic hit;
        a = (b == 0) ? rel_lo + 24'(d) : rel_hi + 24'(d);
        hit = (a >= rel_lo) && (a <= rel_hi);
        disarm();
        send(8'h03, 24'h001800, 40);
        send(8'h03, a, 40);
        if (hit) check(mid_pri_n, 1'b1, "R6 frame stays secondary");
        probe(~hit, "R4 R10 release bound");
      end
    end

    disarm();
    send(8'h0B, 24'h001400, 40);
    probe(1'b0, "R7 fast-read opcode ignored");
    send(8'h02, 24'h001400, 40);
    probe(1'b0, "R7 write opcode ignored");
    send(8'h03, 24'h001400, 40);
    send(8'h02, 24'h00F010, 40);
    check(mid_pri_n, 1'b1, "R7 write passes to secondary");
    probe(1'b1, "R7 write keeps secondary");

    disarm();
    send(8'h03, 24'h001400, 20);
    probe(1'b0, "R9 short frame");
    send(8'h03, 24'h123456, 40);
    probe(1'b0, "R9 outside windows from primary");
    send(8'h03, 24'h001400, 40);
    send(8'h03, 24'h123456, 40);
    probe(1'b1, "R9 outside windows from secondary");

    enable = 1'b0;
    wclk(3);
    probe(1'b0, "R8 enable low");
    enable = 1'b1;
    wclk(3);
    probe(1'b0, "R8 enable restored");

    rel_lo = 24'h001800;
    rel_hi = 24'h0018FF;
    disarm();
    send(8'h03, 24'h001850, 40);
    probe(1'b0, "R5 overlap release wins");
    send(8'h03, 24'h001200, 40);
    probe(1'b1, "R5 arm-only address");
    send(8'h03, 24'h0018FF, 40);
    probe(1'b0, "R5 overlap releases");

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule